// File: doc/BRIEF.md
# Latched Status Register Group

This block is a 16-bit status reporting group for an instrument control interface. Live status lines arrive on one input vector. A condition view shows them as they are at that moment. An event register catches every false-to-true change of a status line and keeps it. An enable mask chooses which of the caught events drive a single summary output, and that output feeds a higher-level status byte.

A register-read port returns the condition view, the event register or the enable mask. Reading the event register returns its contents and clears it in the same access, so software sees each event once. Reading the condition view has no side effect. A separate clear-status strobe empties the event register without reading it.

Four bit positions are in use:
- bit 0: voltage summary
- bit 1: current summary
- bit 9: overvoltage protection
- bit 10: summary

Every other position is tied to zero. The asynchronous active-low reset is released through a two-stage synchronizer, so the block leaves reset on the second rising clock edge after `rst_n` goes high.

Top module: `latched_status_group`

## Requirements
- R1: Reading with `rd_sel` = 2'b00 returns the condition view in the same cycle. The condition view is the live `stat_in` ANDed with the used-bit mask 0x0603 (bits 0, 1, 9 and 10). Unused positions read 0, and a rising edge on an unused position never sets an event bit.
- R2: When a used input bit is high in a cycle and was low in the cycle before, the matching event bit is 1 from the next rising clock edge.
- R3: An input that stays high does not set its event bit again after that bit has been cleared.
- R4: Once set, an event bit stays set when its input falls, until it is cleared by a read or by `clr_stat`.
- R5: Reading with `rd_sel` = 2'b01 and `rd_en` = 1 returns the event register in that cycle and clears it at the next edge. Reading with `rd_sel` = 2'b00 changes nothing.
- R6: A cycle with `clr_stat` = 1 clears the event register at the next edge.
- R7: A rising edge that arrives in the same cycle as an event read or a clear is kept. The read returns the old contents, and the new bit is set after the edge.
- R8: Writing with `en_wr` = 1 loads `en_wr_data` ANDed with 0x0603 into the enable mask at the next edge. Reading with `rd_sel` = 2'b10 returns the mask, and `rd_sel` = 2'b11 returns 0. The mask resets to 0.
- R9: `summary` is 1 exactly when some event bit and its enable bit are both 1.
- R10: Reset clears the event register, the enable mask and the previous-sample register. Inputs already high when reset is released are therefore recorded as events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| stat_in | input | 16 | Live status lines |
| rd_en | input | 1 | Read strobe; an event read clears the event register |
| rd_sel | input | 2 | Read target: 00 condition, 01 event, 10 enable, 11 none |
| rd_data | output | 16 | Read data for the selected target, valid in the same cycle |
| en_wr | input | 1 | Enable mask write strobe |
| en_wr_data | input | 16 | Enable mask write data |
| clr_stat | input | 1 | Clear-status strobe for the event register |
| summary | output | 1 | OR of the enabled event bits |

## Verification
The bench builds the block with its default parameters: width 16 and used-bit mask 0x0603. With these values, unused positions can be driven and shown to stay at zero in every view. Each of the four live positions is driven through rise, hold and fall around event reads and clears. This reaches the same-cycle collisions of an edge with a read and of an edge with a clear. The mask width also lets a full-ones enable write show that only the four used bits are stored.

// File: rtl/status_grp_pkg.sv
package status_grp_pkg;
  localparam int STAT_W = 16;
  localparam logic [STAT_W-1:0] STAT_USED = 16'h0603;

  typedef enum logic [1:0] {
    SEL_COND = 2'b00,
    SEL_EVT  = 2'b01,
    SEL_EN   = 2'b10,
    SEL_NONE = 2'b11
  } rd_sel_e;
endpackage

// File: rtl/stat_edge_cell.sv
module stat_edge_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic cond_i,
  input  logic clr_i,
  output logic evt_o
);
  logic prev_q, prev_d;
  logic evt_q, evt_d;
  logic rise;

  always_comb begin
    rise   = cond_i & ~prev_q;
    prev_d = cond_i;
    if (clr_i) evt_d = rise;
    else       evt_d = evt_q | rise;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      evt_q  <= 1'b0;
    end else begin
      prev_q <= prev_d;
      evt_q  <= evt_d;
    end
  end

  assign evt_o = evt_q;

  assert_rise_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_i && !prev_q) |=> evt_q);
  assert_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_q && !clr_i) |=> evt_q);
  assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !(cond_i && !prev_q)) |=> !evt_q);
  assert_edge_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && cond_i && !prev_q) |=> evt_q);
  assert_no_retrigger_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (prev_q && clr_i) |=> !evt_q);
endmodule

// File: rtl/stat_mask_reg.sv
module stat_mask_reg #(
  parameter int W = 16,
  parameter logic [W-1:0] USED = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] en_o
);
  logic [W-1:0] en_q, en_d;

  always_comb begin
    en_d = en_q;
    if (wr_en) en_d = wr_data & USED;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= en_d;
  end

  assign en_o = en_q;

  assert_mask_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (en_q == ($past(wr_data) & USED)));
  assert_mask_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(en_q));
endmodule

// File: rtl/stat_read_mux.sv
module stat_read_mux
  import status_grp_pkg::*;
#(
  parameter int W = 16
) (
  input  rd_sel_e      sel,
  input  logic [W-1:0] cond_i,
  input  logic [W-1:0] evt_i,
  input  logic [W-1:0] en_i,
  output logic [W-1:0] data_o
);
  always_comb begin
    unique case (sel)
      SEL_COND: data_o = cond_i;
      SEL_EVT:  data_o = evt_i;
      SEL_EN:   data_o = en_i;
      default:  data_o = '0;
    endcase
  end
endmodule

// File: rtl/stat_summary.sv
module stat_summary #(
  parameter int W = 16
) (
  input  logic [W-1:0] evt_i,
  input  logic [W-1:0] en_i,
  output logic         sum_o
);
  always_comb sum_o = |(evt_i & en_i);
endmodule

// File: rtl/latched_status_group.sv
module latched_status_group
  import status_grp_pkg::*;
#(
  parameter int WIDTH = STAT_W,
  parameter logic [WIDTH-1:0] USED_MASK = STAT_USED
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] stat_in,
  input  logic             rd_en,
  input  logic [1:0]       rd_sel,
  output logic [WIDTH-1:0] rd_data,
  input  logic             en_wr,
  input  logic [WIDTH-1:0] en_wr_data,
  input  logic             clr_stat,
  output logic             summary
);
  logic [1:0]       rst_sync_q;
  logic             rst_n_s;
  logic [WIDTH-1:0] cond_w;
  logic [WIDTH-1:0] evt_w;
  logic [WIDTH-1:0] en_w;
  logic             evt_rd;
  logic             evt_clr;
  rd_sel_e          sel_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  assign sel_w   = rd_sel_e'(rd_sel);
  assign cond_w  = stat_in & USED_MASK;
  assign evt_rd  = rd_en && (sel_w == SEL_EVT);
  assign evt_clr = evt_rd | clr_stat;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    if (USED_MASK[i]) begin : g_used
      stat_edge_cell u_cell (
        .clk    (clk),
        .rst_n  (rst_n_s),
        .cond_i (cond_w[i]),
        .clr_i  (evt_clr),
        .evt_o  (evt_w[i])
      );
    end else begin : g_tied
      assign evt_w[i] = 1'b0;
    end
  end

  stat_mask_reg #(.W(WIDTH), .USED(USED_MASK)) u_mask (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .wr_en   (en_wr),
    .wr_data (en_wr_data),
    .en_o    (en_w)
  );

  stat_read_mux #(.W(WIDTH)) u_mux (
    .sel    (sel_w),
    .cond_i (cond_w),
    .evt_i  (evt_w),
    .en_i   (en_w),
    .data_o (rd_data)
  );

  stat_summary #(.W(WIDTH)) u_sum (
    .evt_i (evt_w),
    .en_i  (en_w),
    .sum_o (summary)
  );

  assert_unused_zero_R1: assert property (@(posedge clk) disable iff (!rst_n_s)
    (rd_data & ~USED_MASK) == '0);
  assert_summary_needs_enable_R9: assert property (@(posedge clk) disable iff (!rst_n_s)
    summary |-> (en_w != '0) && (evt_w != '0));
  assert_cond_read_no_clear_R5: assert property (@(posedge clk) disable iff (!rst_n_s)
    (rd_en && sel_w == SEL_COND && !clr_stat && evt_w[0]) |=> evt_w[0]);
  assert_reset_clean_R10: assert property (@(posedge clk)
    !rst_n_s |-> (evt_w == '0) && (en_w == '0) && !summary);
endmodule

// File: tb/latched_status_group_test.sv
module latched_status_group_test;
  localparam time CLK_PERIOD = 10ns;

  logic        clk;
  logic        rst_n;
  logic [15:0] stat_in;
  logic        rd_en;
  logic [1:0]  rd_sel;
  logic [15:0] rd_data;
  logic        en_wr;
  logic [15:0] en_wr_data;
  logic        clr_stat;
  logic        summary;

  int          n_checks;
  int          n_fail;
  bit          done;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  latched_status_group uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .stat_in    (stat_in),
    .rd_en      (rd_en),
    .rd_sel     (rd_sel),
    .rd_data    (rd_data),
    .en_wr      (en_wr),
    .en_wr_data (en_wr_data),
    .clr_stat   (clr_stat),
    .summary    (summary)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Monitor: pops the expected read data whenever a read is active.
  always @(negedge clk) begin
    if (rd_en && exp_q.size() > 0) begin
      logic [15:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_checks++;
      if (rd_data !== e) begin
        n_fail++;
        $display("FAIL %s: rd_data actual %h expected %h", t, rd_data, e);
      end
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
    rd_en    = 1'b0;
    en_wr    = 1'b0;
    clr_stat = 1'b0;
  endtask

  // Driver: one read cycle, expectation pushed for the monitor.
  task automatic do_read(input logic [1:0] sel, input logic [15:0] e, input string t);
    rd_en  = 1'b1;
    rd_sel = sel;
    exp_q.push_back(e);
    tag_q.push_back(t);
    step();
  endtask

  task automatic check_sum(input logic e, input string t);
    @(negedge clk);
    n_checks++;
    if (summary !== e) begin
      n_fail++;
      $display("FAIL %s: summary actual %b expected %b", t, summary, e);
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    n_checks = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; stat_in = 16'hF001; rd_en = 1'b0; rd_sel = 2'b00;
    en_wr = 1'b0; en_wr_data = 16'h0; clr_stat = 1'b0;
    step(); step();
    do_read(2'b10, 16'h0000, "R8 reset enable");
    do_read(2'b01, 16'h0000, "R10 reset event");
    do_read(2'b00, 16'h0001, "R1 cond masks unused");
    check_sum(1'b0, "R10 reset summary");
    rst_n = 1'b1;
    repeat (4) step();
    do_read(2'b01, 16'h0001, "R10 high at reset is event");
    do_read(2'b01, 16'h0000, "R3 held high no retrigger");
    // R5: condition reads have no side effect
    stat_in = 16'h0201; step();
    do_read(2'b00, 16'h0201, "R1 cond live");
    do_read(2'b00, 16'h0201, "R5 cond read again");
    do_read(2'b01, 16'h0200, "R2 rise sets event");
    do_read(2'b01, 16'h0000, "R5 event cleared by read");
    // R4 sticky
    stat_in = 16'h0203; step();
    stat_in = 16'h0201; step(); step();
    do_read(2'b01, 16'h0002, "R4 sticky after fall");
    // R6 clear
    stat_in = 16'h0601; step();
    clr_stat = 1'b1; step();
    do_read(2'b01, 16'h0000, "R6 clear status");
    // R7 edge with read
    stat_in = 16'h0600; step();
    stat_in = 16'h0602; step();
    stat_in = 16'h0603;
    do_read(2'b01, 16'h0002, "R7 read returns old");
    do_read(2'b01, 16'h0001, "R7 edge kept on read");
    // R7 edge with clear
    stat_in = 16'h0403; step();
    stat_in = 16'h0603; clr_stat = 1'b1; step();
    do_read(2'b01, 16'h0200, "R7 edge kept on clear");
    // R1 unused rising edges ignored
    stat_in = 16'h0623; step(); step();
    do_read(2'b01, 16'h0000, "R1 unused edge ignored");
    // R8 enable mask
    en_wr = 1'b1; en_wr_data = 16'hFFFF; step();
    do_read(2'b10, 16'h0603, "R8 enable write masked");
    do_read(2'b11, 16'h0000, "R8 select none reads 0");
    check_sum(1'b0, "R9 no events no summary");
    // R9 summary
    stat_in = 16'h0621; step();
    stat_in = 16'h0623; step();
    check_sum(1'b1, "R9 enabled event raises summary");
    en_wr = 1'b1; en_wr_data = 16'h0001; step();
    check_sum(1'b0, "R9 masked event no summary");
    do_read(2'b01, 16'h0002, "R9 event still held");
    step();
    done = 1'b1;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL scoreboard: actual %0d left expected 0", exp_q.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule